// File: doc/BRIEF.md
# Instruction prefetch queue

This unit sits between an instruction memory port and the decode stage of a pipelined processor. It runs ahead of decode, requesting sequential instruction words from memory and parking them in a four-slot queue. Each slot holds eight bytes of returned instruction data, the slot's fetch address and a size flag. Decode takes words from the head of the queue with a valid/ready handshake. A stall in decode only stops words leaving the queue, so the queue keeps filling until all four slots are taken.

Memory grants each request in the cycle it is made, if it can. With the grant, memory supplies a single pre-decoded size bit that says whether the instruction at that address is 4 or 8 bytes long. The next fetch address is stepped by that size. Returned data comes back later, in grant order, and fills the oldest slot still waiting for data.

When a taken branch resolves, a redirect pulse carries the target address. In that cycle the unit drops every queued entry and asks for no fetch. It marks any fetch still waiting for data as stale, so that data is thrown away when it arrives. Fetching resumes from the target on the next cycle.

Top module: `pf_prefetch_queue`

## Requirements
- R1: In the cycle after a synchronous reset is released, `dec_valid` is 0, `fetch_req` is 1 and `fetch_addr` equals `reset_vec`.
- R2: `fetch_req` is 1 exactly when there is no redirect in the cycle, fewer than four slots are allocated (a slot is allocated from grant until pop) and the R8 bound allows another fetch. It does not depend on `dec_ready`, so the queue fills to four slots while decode stalls.
- R3: A grant (`fetch_req` and `fetch_gnt` both 1) advances `fetch_addr` by 8 when `fetch_gnt_long` is 1 and by 4 when it is 0.
- R4: Responses (`rsp_valid` 1) arrive in grant order, and each live one fills the oldest slot still waiting for data. `dec_valid` is 1 exactly when the head slot is filled. It then shows that slot's fetch address on `dec_pc`, its size bit on `dec_long`, and on `dec_data` the 64-bit response data unchanged.
- R5: The head is popped only in a cycle where `dec_valid` and `dec_ready` are both 1. While `dec_valid` is 1 and `dec_ready` is 0, `dec_pc`, `dec_long` and `dec_data` hold their values into the next cycle.
- R6: In a cycle where `redirect` is 1, `fetch_req` is 0. In the following cycle the queue is empty (`dec_valid` 0) and `fetch_addr` equals the `redirect_target` that was given with the redirect.
- R7: Every response to a fetch granted before a redirect is discarded and never appears on the decode side.
- R8: The number of granted fetches whose data has not yet returned, live or stale, never exceeds four. No request is made while four are outstanding.
- R9: A redirect takes priority over a pop or a response in the same cycle; neither of them leaves any entry in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reset_vec | input | 32 | Fetch address loaded at reset |
| fetch_req | output | 1 | Fetch request to memory |
| fetch_addr | output | 32 | Byte address of the requested word |
| fetch_gnt | input | 1 | Memory accepts the request this cycle |
| fetch_gnt_long | input | 1 | Size bit with the grant: 1 = 8-byte instruction, 0 = 4-byte |
| rsp_valid | input | 1 | Returned data is valid this cycle |
| rsp_data | input | 64 | Returned instruction data |
| dec_valid | output | 1 | Head entry is ready for decode |
| dec_data | output | 64 | Head entry data |
| dec_long | output | 1 | Head entry size bit |
| dec_pc | output | 32 | Head entry fetch address |
| dec_ready | input | 1 | Decode accepts the head entry |
| redirect | input | 1 | Taken-branch flush pulse |
| redirect_target | input | 32 | New fetch address carried with the redirect |

## Verification
The assertions check the following every cycle: fetching stops when all slots are allocated, the address steps on each grant, the head holds steady under a decode stall, each redirect lands on its target and empties the queue, and outstanding fetches stay within the bound. Only the bench's scenarios can show that responses fill slots in grant order and that stale responses after a redirect are really dropped. For that, the bench compares every popped word against the address stream it predicted, while its memory model keeps returning data for the cancelled fetches. Conflicts where a redirect meets a response or a pop in the same cycle are also judged from the decode-side stream that follows.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned PF_AW         = 32;
  localparam int unsigned PF_SLOT_BYTES = 8;
  localparam int unsigned PF_DEPTH      = 4;
  localparam int unsigned PF_SHORT_LEN  = 4;
  localparam int unsigned PF_LONG_LEN   = 8;

  // Byte length selected by the pre-decoded size bit
  function automatic int unsigned pf_len(input logic is_long);
    return is_long ? PF_LONG_LEN : PF_SHORT_LEN;
  endfunction
endpackage

// File: rtl/pf_fetch_addr.sv
module pf_fetch_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vec,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_target,
  input  logic          take,
  input  logic          take_long,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic lng);
    return a + AW'(pf_pkg::pf_len(lng));
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           addr <= reset_vec;
    else if (redirect) addr <= redirect_target;
    else if (take)     addr <= step_addr(addr, take_long);
  end
endmodule

// File: rtl/pf_inflight.sv
module pf_inflight #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          rsp_valid,
  input  logic          redirect,
  output logic [CW-1:0] pend_cnt,
  output logic [CW-1:0] disc_cnt,
  output logic          rsp_live,
  output logic          can_issue
);
  logic          rsp_drop;
  logic [CW:0]   total;

  assign total     = {1'b0, pend_cnt} + {1'b0, disc_cnt};
  assign can_issue = total < (CW+1)'(DEPTH);
  assign rsp_live  = rsp_valid && (disc_cnt == '0) && !redirect;
  assign rsp_drop  = rsp_valid && (disc_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cnt <= '0;
      disc_cnt <= '0;
    end else if (redirect) begin
      // everything still outstanding becomes stale
      pend_cnt <= '0;
      disc_cnt <= CW'(total - (CW+1)'(rsp_valid));
    end else begin
      pend_cnt <= pend_cnt + CW'(alloc) - CW'(rsp_live);
      disc_cnt <= disc_cnt - CW'(rsp_drop);
    end
  end
endmodule

// File: rtl/pf_slot_ring.sv
module pf_slot_ring #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 64,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_addr,
  input  logic          alloc_long,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          head_valid,
  output logic [DW-1:0] head_data,
  output logic          head_long,
  output logic [AW-1:0] head_addr
);
  logic [PW-1:0] head_ptr, tail_ptr, fill_ptr;
  logic [AW-1:0] s_addr [DEPTH];
  logic [DW-1:0] s_data [DEPTH];
  logic          s_long [DEPTH];
  logic          s_full [DEPTH];
  logic          pop_eff;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_valid = (count != '0) && s_full[head_ptr];
  assign head_data  = s_data[head_ptr];
  assign head_long  = s_long[head_ptr];
  assign head_addr  = s_addr[head_ptr];
  assign pop_eff    = pop && head_valid;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic alloc_here, fill_here;
    assign alloc_here = alloc && (tail_ptr == PW'(g));
    assign fill_here  = fill  && (fill_ptr == PW'(g));
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        s_full[g] <= 1'b0;
      end else if (alloc_here) begin
        s_full[g] <= 1'b0;
        s_addr[g] <= alloc_addr;
        s_long[g] <= alloc_long;
      end else if (fill_here) begin
        s_full[g] <= 1'b1;
        s_data[g] <= fill_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      fill_ptr <= '0;
      count    <= '0;
    end else begin
      if (pop_eff) head_ptr <= ptr_next(head_ptr);
      if (alloc)   tail_ptr <= ptr_next(tail_ptr);
      if (fill)    fill_ptr <= ptr_next(fill_ptr);
      count <= count + CW'(alloc) - CW'(pop_eff);
    end
  end
endmodule

// File: rtl/pf_prefetch_queue.sv
module pf_prefetch_queue #(
  parameter int unsigned DEPTH      = pf_pkg::PF_DEPTH,
  parameter int unsigned ADDR_W     = pf_pkg::PF_AW,
  parameter int unsigned SLOT_BYTES = pf_pkg::PF_SLOT_BYTES,
  localparam int unsigned DATA_W    = SLOT_BYTES * 8,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reset_vec,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_gnt,
  input  logic              fetch_gnt_long,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data,
  output logic              dec_long,
  output logic [ADDR_W-1:0] dec_pc,
  input  logic              dec_ready,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_target
);
  // named internal events, also observed by the bound checker
  logic [CW-1:0] ring_count;
  logic [CW-1:0] pend_cnt;
  logic [CW-1:0] disc_cnt;
  logic          can_issue;
  logic          rsp_live;
  logic          ring_has_room;
  logic          fetch_take;
  logic          pop_take;

  assign ring_has_room = ring_count < CW'(DEPTH);
  assign fetch_req     = !redirect && ring_has_room && can_issue;
  assign fetch_take    = fetch_req && fetch_gnt;
  assign pop_take      = dec_valid && dec_ready && !redirect;

  pf_fetch_addr #(.AW(ADDR_W)) u_addr (
    .clk             (clk),
    .rst             (rst),
    .reset_vec       (reset_vec),
    .redirect        (redirect),
    .redirect_target (redirect_target),
    .take            (fetch_take),
    .take_long       (fetch_gnt_long),
    .addr            (fetch_addr)
  );

  pf_inflight #(.DEPTH(DEPTH)) u_inflight (
    .clk       (clk),
    .rst       (rst),
    .alloc     (fetch_take),
    .rsp_valid (rsp_valid),
    .redirect  (redirect),
    .pend_cnt  (pend_cnt),
    .disc_cnt  (disc_cnt),
    .rsp_live  (rsp_live),
    .can_issue (can_issue)
  );

  pf_slot_ring #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .flush      (redirect),
    .alloc      (fetch_take),
    .alloc_addr (fetch_addr),
    .alloc_long (fetch_gnt_long),
    .fill       (rsp_live),
    .fill_data  (rsp_data),
    .pop        (pop_take),
    .count      (ring_count),
    .head_valid (dec_valid),
    .head_data  (dec_data),
    .head_long  (dec_long),
    .head_addr  (dec_pc)
  );
endmodule

// File: rtl/pf_prefetch_checker.sv
module pf_prefetch_checker #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reset_vec,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirect_target,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_gnt_long,
  input logic              fetch_take,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic [DATA_W-1:0] dec_data,
  input logic [ADDR_W-1:0] dec_pc,
  input logic              dec_long,
  input logic [CW-1:0]     ring_count,
  input logic [CW-1:0]     pend_cnt,
  input logic [CW-1:0]     disc_cnt
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_addr == $past(reset_vec)) && !dec_valid);

  a_r2_full_no_req: assert property (@(posedge clk) disable iff (rst)
    (ring_count == CW'(DEPTH)) |-> !fetch_req);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    fetch_take |=> fetch_addr == $past(fetch_addr) +
      ($past(fetch_gnt_long) ? ADDR_W'(8) : ADDR_W'(4)));

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready && !redirect) |=>
      dec_valid && $stable(dec_pc) && $stable(dec_data) && $stable(dec_long));

  a_r6_no_req_on_redirect: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !fetch_req);

  a_r6_redirect_lands: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (fetch_addr == $past(redirect_target)) && !dec_valid && (ring_count == '0));

  a_r8_outstanding_bound: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, pend_cnt} + {1'b0, disc_cnt}) <= (CW+1)'(DEPTH));
endmodule

bind pf_prefetch_queue pf_prefetch_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_pf_chk (
  .clk             (clk),
  .rst             (rst),
  .reset_vec       (reset_vec),
  .redirect        (redirect),
  .redirect_target (redirect_target),
  .fetch_req       (fetch_req),
  .fetch_addr      (fetch_addr),
  .fetch_gnt_long  (fetch_gnt_long),
  .fetch_take      (fetch_take),
  .dec_valid       (dec_valid),
  .dec_ready       (dec_ready),
  .dec_data        (dec_data),
  .dec_pc          (dec_pc),
  .dec_long        (dec_long),
  .ring_count      (ring_count),
  .pend_cnt        (pend_cnt),
  .disc_cnt        (disc_cnt)
);

// File: tb/test_pf_prefetch_queue.sv
`timescale 1ns/1ps
module test_pf_prefetch_queue;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] reset_vec = 32'h0000_1000;
  logic          fetch_req, fetch_gnt = 1'b0, fetch_gnt_long = 1'b0;
  logic [AW-1:0] fetch_addr;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic          dec_valid, dec_long, dec_ready = 1'b0;
  logic [DW-1:0] dec_data;
  logic [AW-1:0] dec_pc;
  logic          redirect = 1'b0;
  logic [AW-1:0] redirect_target = '0;

  pf_prefetch_queue i_pf_prefetch_queue (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic [AW-1:0] m_addr[$]; int m_due[$]; int m_ep[$];
  logic [AW-1:0] e_pc[$];   bit e_long[$]; int e_filled = 0;
  logic [AW-1:0] e_next;
  int  epoch = 0, cyc = 0;
  bit  prev_redir = 0, prev_conflict = 0, prev_stale = 0, prev_stall = 0;
  logic [AW-1:0] prev_pc; logic [DW-1:0] prev_data;
  int  p_ready = 50, p_gnt = 60, p_redir = 20, max_lat = 3;
  bit  force_redir = 0;

  function automatic logic [DW-1:0] mk_data(input logic [AW-1:0] a);
    return {~a, a};
  endfunction
  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input bit lng);
    return a + (lng ? 32'd8 : 32'd4);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit do_redir, do_rsp, exp_req, exp_valid, pop, live, stale;
    string vl, rl;
    logic [AW-1:0] tgt;
    @(negedge clk);
    exp_valid = (e_pc.size() > 0) && (e_filled > 0);
    vl = prev_conflict ? "R9" : prev_redir ? "R6" : prev_stale ? "R7" : "R4";
    chk(dec_valid == exp_valid, vl, "dec_valid", 64'(dec_valid), 64'(exp_valid));
    if (prev_stall)
      chk(dec_valid && dec_pc == prev_pc && dec_data == prev_data, "R5",
          "head held under stall", dec_data, prev_data);
    do_redir = force_redir || (int'($urandom % 1000) < p_redir);
    tgt = $urandom & 32'hFFFF_FFFC;
    do_rsp = (m_addr.size() > 0) && (m_due[0] <= cyc);
    redirect = do_redir;
    redirect_target = tgt;
    rsp_valid = do_rsp;
    rsp_data = do_rsp ? mk_data(m_addr[0]) : '0;
    dec_ready = int'($urandom % 100) < p_ready;
    #1;
    exp_req = !do_redir && (e_pc.size() < DEPTH) && (m_addr.size() < DEPTH);
    rl = do_redir ? "R6" : (e_pc.size() >= DEPTH) ? "R2" :
         (m_addr.size() >= DEPTH) ? "R8" : "R2";
    chk(fetch_req == exp_req, rl, "fetch_req", 64'(fetch_req), 64'(exp_req));
    if (fetch_req && exp_req)
      chk(fetch_addr == e_next, prev_redir ? "R6" : "R3", "fetch_addr",
          64'(fetch_addr), 64'(e_next));
    fetch_gnt = fetch_req && (int'($urandom % 100) < p_gnt);
    fetch_gnt_long = $urandom % 2;
    pop = dec_valid && dec_ready && !do_redir;
    if (pop) begin
      if (e_pc.size() == 0) chk(0, "R4", "pop with empty model", 64'(dec_pc), 64'(0));
      else begin
        chk(dec_pc == e_pc[0], "R4", "dec_pc", 64'(dec_pc), 64'(e_pc[0]));
        chk(dec_long == e_long[0], "R4", "dec_long", 64'(dec_long), 64'(e_long[0]));
        chk(dec_data == mk_data(e_pc[0]), "R4", "dec_data", dec_data, mk_data(e_pc[0]));
      end
    end
    prev_stall = dec_valid && !dec_ready && !do_redir;
    prev_pc = dec_pc; prev_data = dec_data;
    prev_conflict = do_redir && (do_rsp || (dec_valid && dec_ready));
    stale = 0;
    if (do_rsp) begin
      live = (m_ep[0] == epoch) && !do_redir;
      stale = (m_ep[0] != epoch);
      void'(m_addr.pop_front()); void'(m_due.pop_front()); void'(m_ep.pop_front());
      if (live) e_filled++;
    end
    prev_stale = stale;
    if (pop && e_pc.size() > 0) begin
      void'(e_pc.pop_front()); void'(e_long.pop_front()); e_filled--;
    end
    if (fetch_gnt) begin
      m_addr.push_back(fetch_addr);
      m_due.push_back(cyc + 1 + int'($urandom % max_lat));
      m_ep.push_back(epoch);
      e_pc.push_back(e_next); e_long.push_back(fetch_gnt_long);
      e_next = nxt(e_next, fetch_gnt_long);
    end
    if (do_redir) begin
      e_pc.delete(); e_long.delete(); e_filled = 0;
      e_next = tgt; epoch++;
    end
    prev_redir = do_redir;
    cyc++;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(!dec_valid, "R1", "dec_valid after reset", 64'(dec_valid), 64'(0));
    chk(fetch_req, "R1", "fetch_req after reset", 64'(fetch_req), 64'(1));
    chk(fetch_addr == reset_vec, "R1", "fetch_addr after reset", 64'(fetch_addr), 64'(reset_vec));
    e_next = reset_vec;
    // R2: decode stalled, queue fills to all four slots, then drains
    p_ready = 0; p_gnt = 100; p_redir = 0; max_lat = 1;
    repeat (30) step();
    chk(e_pc.size() == DEPTH && !fetch_req, "R2", "queue full under stall",
        64'(e_pc.size()), 64'(DEPTH));
    p_ready = 100;
    repeat (30) step();
    // R7, R8: slow memory, redirect with fetches outstanding
    p_ready = 0; max_lat = 8;
    repeat (4) step();
    force_redir = 1; step(); force_redir = 0;
    p_ready = 100;
    repeat (30) step();
    // R9: back-to-back redirects with responses and pops in flight
    max_lat = 2;
    repeat (5) step();
    force_redir = 1; repeat (2) step(); force_redir = 0;
    repeat (20) step();
    // mixed random traffic
    for (int k = 0; k < 6; k++) begin
      p_ready = 20 + 15 * k; p_gnt = 40 + 10 * k; p_redir = 10 + 10 * k; max_lat = 1 + (k % 4);
      repeat (400) step();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule